// File: doc/BRIEF.md
# Banked Scratchpad with Conflict Serialization

This block is a multi-bank on-chip scratchpad shared by a group of parallel lanes. One request carries, for every lane, an enable, a write flag, a word address and 32 bits of write data. Words are spread across the banks one word per bank in turn. The block finds lanes whose distinct addresses collide in one bank and serves the request as the fewest passes that are free of conflicts. Each bank moves one 32-bit word per pass.

A group of 32 lanes is split into two halves of 16. The lower half is finished before the upper half starts, and collisions are only counted inside a half. When the whole request is finished, the block raises a one-cycle done pulse and reports the conflict degree. Read results stay in per-lane registers.

The controller has three states. IDLE takes a request when `req_valid` is high (IDLE to SERVE). SERVE runs one pass per cycle on the current half. When that half has nothing left, SERVE moves on to the next half, or goes to DONE after the last half (SERVE to DONE). DONE lasts one cycle and returns to IDLE (DONE to IDLE).

Top module: `bsp_scratchpad`

## Requirements
- R1: The bank of a word address is its low log2(BANKS) bits and the row is the remaining upper bits. A word written at an address is returned by a later read of that same address.
- R2: When the enabled lanes of a half all fall in distinct banks, that half is served in one pass and `conflict_degree` reads 1.
- R3: Lanes of a half that present the identical address are served in the same pass and add no conflict (a broadcast read of one word by all lanes gives degree 1).
- R4: A half needs as many passes as the largest number of distinct addresses mapped to one bank in it. `conflict_degree` is the largest such count over the halves, and 0 for a request with no enabled lane.
- R5: Lanes 0 to 15 are fully served before lanes 16 to 31. A write in the lower half is therefore visible to a read of the same address in the upper half. Each half takes max(passes,1) cycles in SERVE.
- R6: In each pass, the lowest-numbered pending lane of a bank picks that bank's address. A read served in the same pass as a write to its address returns the old content.
- R7: When several lanes write one address in the same pass, the data of the highest-numbered of them is stored.
- R8: `req_ready` is high only in IDLE, and a request is taken on a clock edge with `req_valid` and `req_ready` both high. `done` is high for exactly one cycle, a number of cycles after acceptance equal to the summed SERVE cycles, and `req_ready` returns on the next cycle.
- R9: The `rd_data` of a reading lane changes on the clock edge that ends its pass. Lanes that are disabled or writing keep their previous `rd_data`, and `rd_data` does not change while the block is idle.
- R10: After reset, `req_ready` is 1, `done` is 0, `conflict_degree` is 0 and every `rd_data` lane is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and takes a request |
| req_lane_en | input | GROUP_LANES | Lane takes part in the request |
| req_we | input | GROUP_LANES | Lane writes (1) or reads (0) |
| req_addr | input | GROUP_LANES x log2(BANKS*ROWS) | Word address per lane |
| req_wdata | input | GROUP_LANES x 32 | Write data per lane |
| rd_data | output | GROUP_LANES x 32 | Registered read result per lane |
| done | output | 1 | One-cycle pulse when the request is finished |
| conflict_degree | output | log2(HALF_LANES+1) | Largest pass count over the halves, valid with done |

## Verification
The assertions check the handshake on every cycle. They cover `req_ready` falling after acceptance and staying low through `done`, `done` lasting a single cycle, a return to ready right after it, the degree staying within the lane count of a half, and `rd_data` holding still while idle. The bench's scenarios are the only evidence for the bank mapping and pass count, the order of passes and of halves, read-old behaviour inside a pass, the rule that the highest lane wins a write, and exact latency. The bench covers these with a pass-level reference model run against striped, strided, broadcast, colliding, empty and pseudo-random requests.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_SERVE = 2'd1,
        S_DONE  = 2'd2
    } bsp_state_e;
endpackage

// File: rtl/bsp_bank.sv
module bsp_bank import bsp_pkg::*; #(
    parameter int ROWS = 32
) (
    input  logic                     clk,
    input  logic [$clog2(ROWS)-1:0]  row,
    input  logic                     wr_en,
    input  logic [WORD_W-1:0]        wr_data,
    output logic [WORD_W-1:0]        rd_data
);
    logic [WORD_W-1:0] mem [ROWS];

    // Write lands at the edge; read is combinational, so a same-pass read sees old data.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[row] <= wr_data;
        end
    end

    assign rd_data = mem[row];
endmodule

// File: rtl/bsp_pass_select.sv
module bsp_pass_select import bsp_pkg::*; #(
    parameter int LANES  = 16,
    parameter int BANKS  = 16,
    parameter int ADDR_W = 9
) (
    input  logic [LANES-1:0]              pending,
    input  logic [LANES-1:0][ADDR_W-1:0]  addr,
    input  logic [LANES-1:0]              we,
    input  logic [LANES-1:0][WORD_W-1:0]  wdata,
    output logic [LANES-1:0]              served,
    output logic [BANKS-1:0][ADDR_W-1:0]  bank_addr,
    output logic [BANKS-1:0]              bank_we,
    output logic [BANKS-1:0][WORD_W-1:0]  bank_wdata
);
    localparam int BANK_W = $clog2(BANKS);

    always_comb begin
        bank_addr  = '0;
        bank_we    = '0;
        bank_wdata = '0;
        served     = '0;
        // Scan downward so the lowest pending lane of each bank is the last to set it.
        for (int b = 0; b < BANKS; b++) begin
            for (int l = LANES - 1; l >= 0; l--) begin
                if (pending[l] && (addr[l][BANK_W-1:0] == BANK_W'(b))) begin
                    bank_addr[b] = addr[l];
                end
            end
        end
        // Every pending lane matching its bank's pick is served; ascending order lets the top writer win.
        for (int l = 0; l < LANES; l++) begin
            if (pending[l] && (addr[l] == bank_addr[addr[l][BANK_W-1:0]])) begin
                served[l] = 1'b1;
                if (we[l]) begin
                    bank_we[addr[l][BANK_W-1:0]]    = 1'b1;
                    bank_wdata[addr[l][BANK_W-1:0]] = wdata[l];
                end
            end
        end
    end
endmodule

// File: rtl/bsp_scratchpad.sv
module bsp_scratchpad import bsp_pkg::*; #(
    parameter int GROUP_LANES = 32,
    parameter int HALF_LANES  = 16,
    parameter int BANKS       = 16,
    parameter int ROWS        = 32
) (
    input  logic                                              clk,
    input  logic                                              rst_n,
    input  logic                                              req_valid,
    output logic                                              req_ready,
    input  logic [GROUP_LANES-1:0]                            req_lane_en,
    input  logic [GROUP_LANES-1:0]                            req_we,
    input  logic [GROUP_LANES-1:0][$clog2(BANKS*ROWS)-1:0]    req_addr,
    input  logic [GROUP_LANES-1:0][WORD_W-1:0]                req_wdata,
    output logic [GROUP_LANES-1:0][WORD_W-1:0]                rd_data,
    output logic                                              done,
    output logic [$clog2(HALF_LANES+1)-1:0]                   conflict_degree
);
    localparam int ADDR_W     = $clog2(BANKS*ROWS);
    localparam int BANK_W     = $clog2(BANKS);
    localparam int NUM_HALVES = GROUP_LANES / HALF_LANES;
    localparam int HALF_W     = (NUM_HALVES > 1) ? $clog2(NUM_HALVES) : 1;
    localparam int DEG_W      = $clog2(HALF_LANES + 1);

    bsp_state_e state_q, state_d;

    logic [GROUP_LANES-1:0]               en_q, we_q;
    logic [GROUP_LANES-1:0][ADDR_W-1:0]   addr_q;
    logic [GROUP_LANES-1:0][WORD_W-1:0]   wdata_q;
    logic [GROUP_LANES-1:0][WORD_W-1:0]   rd_q;
    logic [HALF_LANES-1:0]                pending_q;
    logic [HALF_W-1:0]                    half_q;
    logic [DEG_W-1:0]                     pass_cnt_q, deg_q, count_now;

    logic [HALF_LANES-1:0]                half_en   [NUM_HALVES];
    logic [HALF_LANES-1:0]                half_we   [NUM_HALVES];
    logic [HALF_LANES-1:0][ADDR_W-1:0]    half_addr [NUM_HALVES];
    logic [HALF_LANES-1:0][WORD_W-1:0]    half_wd   [NUM_HALVES];

    logic [HALF_LANES-1:0]                cur_we, served, pend_sel, pend_left;
    logic [HALF_LANES-1:0][ADDR_W-1:0]    cur_addr;
    logic [HALF_LANES-1:0][WORD_W-1:0]    cur_wd;
    logic [BANKS-1:0][ADDR_W-1:0]         bank_addr;
    logic [BANKS-1:0]                     bank_we;
    logic [BANKS-1:0][WORD_W-1:0]         bank_wdata;
    logic [WORD_W-1:0]                    bank_rdata [BANKS];
    logic                                 in_serve, last_half, half_finished;

    // Per-half views of the captured request
    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        assign half_en[h]   = en_q[h*HALF_LANES +: HALF_LANES];
        assign half_we[h]   = we_q[h*HALF_LANES +: HALF_LANES];
        assign half_addr[h] = addr_q[h*HALF_LANES +: HALF_LANES];
        assign half_wd[h]   = wdata_q[h*HALF_LANES +: HALF_LANES];
    end

    assign in_serve      = (state_q == S_SERVE);
    assign cur_we        = half_we[half_q];
    assign cur_addr      = half_addr[half_q];
    assign cur_wd        = half_wd[half_q];
    assign pend_sel      = in_serve ? pending_q : '0;
    assign pend_left     = pending_q & ~served;
    assign half_finished = (pend_left == '0);
    assign last_half     = (half_q == HALF_W'(NUM_HALVES - 1));
    assign count_now     = (pending_q != '0) ? pass_cnt_q + 1'b1 : pass_cnt_q;

    bsp_pass_select #(
        .LANES  (HALF_LANES),
        .BANKS  (BANKS),
        .ADDR_W (ADDR_W)
    ) u_select (
        .pending    (pend_sel),
        .addr       (cur_addr),
        .we         (cur_we),
        .wdata      (cur_wd),
        .served     (served),
        .bank_addr  (bank_addr),
        .bank_we    (bank_we),
        .bank_wdata (bank_wdata)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        bsp_bank #(.ROWS(ROWS)) u_bank (
            .clk     (clk),
            .row     (bank_addr[b][ADDR_W-1:BANK_W]),
            .wr_en   (bank_we[b] && in_serve),
            .wr_data (bank_wdata[b]),
            .rd_data (bank_rdata[b])
        );
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (req_valid) state_d = S_SERVE;
            S_SERVE: if (half_finished && last_half) state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready       = (state_q == S_IDLE);
        done            = (state_q == S_DONE);
        conflict_degree = deg_q;
        rd_data         = rd_q;
    end

    // Request capture, pass bookkeeping and half sequencing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q       <= '0;
            we_q       <= '0;
            addr_q     <= '0;
            wdata_q    <= '0;
            pending_q  <= '0;
            half_q     <= '0;
            pass_cnt_q <= '0;
            deg_q      <= '0;
        end else if (state_q == S_IDLE && req_valid) begin
            en_q       <= req_lane_en;
            we_q       <= req_we;
            addr_q     <= req_addr;
            wdata_q    <= req_wdata;
            pending_q  <= req_lane_en[HALF_LANES-1:0];
            half_q     <= '0;
            pass_cnt_q <= '0;
            deg_q      <= '0;
        end else if (in_serve) begin
            if (half_finished) begin
                if (count_now > deg_q) begin
                    deg_q <= count_now;
                end
                pass_cnt_q <= '0;
                if (!last_half) begin
                    half_q    <= half_q + 1'b1;
                    pending_q <= half_en[half_q + 1'b1];
                end else begin
                    pending_q <= '0;
                end
            end else begin
                pending_q  <= pend_left;
                pass_cnt_q <= count_now;
            end
        end
    end

    // Per-lane read result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (in_serve) begin
            for (int h = 0; h < NUM_HALVES; h++) begin
                for (int i = 0; i < HALF_LANES; i++) begin
                    if (half_q == HALF_W'(h) && served[i] && !cur_we[i]) begin
                        rd_q[h*HALF_LANES + i] <= bank_rdata[cur_addr[i][BANK_W-1:0]];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/bsp_scratchpad_chk.sv
module bsp_scratchpad_chk import bsp_pkg::*; #(
    parameter int GROUP_LANES = 32,
    parameter int HALF_LANES  = 16
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                req_valid,
    input logic                                req_ready,
    input logic [GROUP_LANES-1:0][WORD_W-1:0]  rd_data,
    input logic                                done,
    input logic [$clog2(HALF_LANES+1)-1:0]     conflict_degree
);
    // R8: no request is taken while the done pulse is out
    a_r8_busy_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_ready);

    // R8: done lasts one cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: ready comes back right after done
    a_r8_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready);

    // R8: an accepted request makes the block busy
    a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R4: degree never exceeds the lanes of one half
    a_r4_degree_bound: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(conflict_degree) <= HALF_LANES));

    // R9: read results hold while idle
    a_r9_rd_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> $stable(rd_data));
endmodule

bind bsp_scratchpad bsp_scratchpad_chk #(
    .GROUP_LANES (GROUP_LANES),
    .HALF_LANES  (HALF_LANES)
) i_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_ready       (req_ready),
    .rd_data         (rd_data),
    .done            (done),
    .conflict_degree (conflict_degree)
);

// File: tb/test_bsp_scratchpad.sv
`timescale 1ns/1ps
module test_bsp_scratchpad;
    localparam int G  = 32;
    localparam int H  = 16;
    localparam int B  = 16;
    localparam int RW = 32;
    localparam int AW = $clog2(B*RW);
    localparam int DW = $clog2(H+1);
    localparam int NW = B*RW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [G-1:0] req_lane_en = '0;
    logic [G-1:0] req_we = '0;
    logic [G-1:0][AW-1:0] req_addr = '0;
    logic [G-1:0][31:0] req_wdata = '0;
    logic [G-1:0][31:0] rd_data;
    logic done;
    logic [DW-1:0] conflict_degree;

    always #2.5 clk = ~clk;

    bsp_scratchpad #(.GROUP_LANES(G), .HALF_LANES(H), .BANKS(B), .ROWS(RW)) i_bsp_scratchpad (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_lane_en(req_lane_en), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .rd_data(rd_data), .done(done),
        .conflict_degree(conflict_degree)
    );

    typedef struct {
        string            tag;
        int               deg;
        int               lat;
        int               acc;
        logic [G-1:0][31:0] rd;
    } item_t;

    item_t sb_q[$];
    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    bit reported = 0;

    logic [31:0] m_mem [NW];
    logic [G-1:0][31:0] m_rd = '0;
    logic [G-1:0] d_en, d_we;
    logic [G-1:0][AW-1:0] d_addr;
    logic [G-1:0][31:0] d_wd;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    // Driver: reference model of the pass rules, then the handshake
    task automatic issue(input string tag);
        item_t it;
        logic [H-1:0] pend, srv;
        logic [AW-1:0] pick [B];
        bit has [B];
        int p, g, bk;
        it.lat = 0;
        it.deg = 0;
        for (int h = 0; h < G/H; h++) begin
            pend = d_en[h*H +: H];
            p = 0;
            while (pend != '0) begin
                p++;
                for (int b = 0; b < B; b++) has[b] = 0;
                for (int i = 0; i < H; i++) begin
                    g = h*H + i;
                    bk = int'(d_addr[g]) % B;
                    if (pend[i] && !has[bk]) begin has[bk] = 1; pick[bk] = d_addr[g]; end
                end
                srv = '0;
                for (int i = 0; i < H; i++) begin
                    g = h*H + i;
                    bk = int'(d_addr[g]) % B;
                    if (pend[i] && d_addr[g] == pick[bk]) srv[i] = 1'b1;
                end
                for (int i = 0; i < H; i++) begin
                    g = h*H + i;
                    if (srv[i] && !d_we[g]) m_rd[g] = m_mem[d_addr[g]];
                end
                for (int i = 0; i < H; i++) begin
                    g = h*H + i;
                    if (srv[i] && d_we[g]) m_mem[d_addr[g]] = d_wd[g];
                end
                pend &= ~srv;
            end
            it.lat += (p == 0) ? 1 : p;
            if (p > it.deg) it.deg = p;
        end
        it.rd = m_rd;
        it.tag = tag;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_lane_en = d_en; req_we = d_we; req_addr = d_addr; req_wdata = d_wd;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        it.acc = cyc;
        sb_q.push_back(it);
        req_valid = 1'b0;
    endtask

    // Monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb_q.size() == 0) begin
                check("R8", "unexpected done", 1, 0);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                check(it.tag, "conflict_degree", conflict_degree, it.deg);
                check(it.tag, "latency R8", cyc - it.acc, it.lat);
                check("R8", "ready during done", req_ready, 0);
                for (int l = 0; l < G; l++)
                    check(it.tag, $sformatf("rd_data lane %0d (R9)", l), rd_data[l], it.rd[l]);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check("ALL", "watchdog expired", 1, 0);
        report();
    end

    initial begin
        for (int a = 0; a < NW; a++) m_mem[a] = 'x;
        repeat (3) @(negedge clk);
        // R10: reset values
        check("R10", "req_ready", req_ready, 1);
        check("R10", "done", done, 0);
        check("R10", "conflict_degree", conflict_degree, 0);
        check("R10", "rd_data", (rd_data == '0), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", "req_ready after release", req_ready, 1);

        // R1/R2: fill memory, 32 consecutive words per request
        for (int k = 0; k < NW/G; k++) begin
            for (int l = 0; l < G; l++) begin
                d_en[l] = 1'b1; d_we[l] = 1'b1;
                d_addr[l] = AW'(k*G + l);
                d_wd[l] = 32'hC0DE0000 ^ (32'(k*G + l) * 32'h00010003);
            end
            issue("R1 R2 fill");
        end
        // R1/R2: read back with stride 17 (distinct banks per half)
        for (int l = 0; l < G; l++) begin
            d_en[l] = 1'b1; d_we[l] = 1'b0; d_addr[l] = AW'((l*17 + 3) % NW); d_wd[l] = '0;
        end
        issue("R1 R2 stride17 read");
        // R3: broadcast of one word
        for (int l = 0; l < G; l++) d_addr[l] = AW'(7);
        issue("R3 broadcast");
        // R4: stride 2 gives 2-way per half
        for (int l = 0; l < G; l++) d_addr[l] = AW'((2*l) % 32 + 64*(l/H));
        issue("R4 two-way");
        // R4/R5: stride 16 in the lower half only, 16-way; upper half idle pass
        for (int l = 0; l < G; l++) begin
            d_en[l] = (l < H); d_addr[l] = AW'(16*l + 5);
        end
        issue("R4 R5 sixteen-way");
        // R4: no lanes enabled
        d_en = '0;
        issue("R4 empty");
        // R7: lanes 3 and 9 write one address in one pass, then read it
        d_en = '0; d_we = '0;
        d_en[3] = 1'b1; d_we[3] = 1'b1; d_addr[3] = AW'(40); d_wd[3] = 32'hAAAA0003;
        d_en[9] = 1'b1; d_we[9] = 1'b1; d_addr[9] = AW'(40); d_wd[9] = 32'hBBBB0009;
        issue("R7 write collision");
        d_en = '0; d_we = '0;
        d_en[0] = 1'b1; d_addr[0] = AW'(40);
        issue("R7 readback");
        // R6: read and write of one address in the same pass, plus a bank loser
        d_en = '0; d_we = '0;
        d_en[0] = 1'b1; d_addr[0] = AW'(5);
        d_en[1] = 1'b1; d_we[1] = 1'b1; d_addr[1] = AW'(5); d_wd[1] = 32'h5EED0001;
        d_en[2] = 1'b1; d_addr[2] = AW'(21);
        issue("R6 read-old");
        // R5: lower-half write visible to upper-half read of the same address
        d_en = '0; d_we = '0;
        d_en[0] = 1'b1; d_we[0] = 1'b1; d_addr[0] = AW'(100); d_wd[0] = 32'h0F0F1234;
        d_en[16] = 1'b1; d_addr[16] = AW'(100);
        issue("R5 half order");
        // R6/R9: pseudo-random mixes
        for (int n = 0; n < 40; n++) begin
            for (int l = 0; l < G; l++) begin
                d_en[l] = ($urandom % 4) != 0;
                d_we[l] = ($urandom % 3) == 0;
                d_addr[l] = AW'((n % 2 == 0) ? ($urandom % NW) : (($urandom % 4) * 16 + (l % 4)));
                d_wd[l] = $urandom;
            end
            issue("R6 R9 random");
        end
        while (sb_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        report();
    end
endmodule